// File: doc/BRIEF.md
# Serial-to-SPI Flash Command Bridge

This block connects a byte-wide host link to a serial flash device. The host link carries bytes in each direction, each with a valid/ready handshake. The flash side is a four-wire SPI master that the block drives itself: chip select, serial clock, and one data line out and one in. An enable pulse while idle puts the block in bridge mode. It answers with a single ready byte and then serves framed transactions until the host asks it to leave.

A frame starts with two count bytes: how many bytes go out to the flash, then how many bytes come back. The outgoing data bytes follow. The block selects the flash and shifts each data byte out as it arrives. It then clocks in the requested number of bytes, sending zeros while it does, and offers each one to the host. Chip select is released once, at the end of the frame. A frame whose two counts are both zero ends bridge mode and touches the flash not at all.

Top module: `spi_flash_bridge`

## Requirements
- R1: An `enable` pulse while idle raises `active` and makes the block offer exactly one byte of value 0x05 on the transmit side before it accepts any host byte.
- R2: In each frame, the first accepted host byte is the write count and the second is the read count. The next write-count host bytes are shifted out on `spi_mosi` in the order received, MSB first, in SPI mode 0: data is stable while `spi_sclk` rises and changes after it falls.
- R3: After the write phase, the block offers exactly read-count bytes on the transmit side. Each byte holds eight `spi_miso` bits sampled on successive rising `spi_sclk` edges, with the first sampled bit as the MSB.
- R4: A frame with a nonzero count drives `spi_cs_n` low exactly once. It stays low from before the first clock edge of the write phase through the last bit of the read phase, then returns high.
- R5: A frame with both counts zero makes `active` fall, and `spi_cs_n` never goes low for it.
- R6: A frame with only one nonzero count is valid: the empty phase is skipped, and the next frame is accepted afterwards.
- R7: During the read phase, `spi_mosi` carries 0x00 for every byte clocked.
- R8: `rx_ready` is never high in a cycle where `tx_valid` is high, so no host byte is taken while a byte is waiting to be sent.
- R9: `spi_sclk` is low whenever `spi_cs_n` is high.
- R10: Counts of 255 are honoured: a frame with 255 write bytes and 255 read bytes moves all 510 bytes under a single chip select.
- R11: After reset, `active` and `tx_valid` are low, `rx_ready` is low, and `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Pulse to enter bridge mode (used only when idle) |
| rx_data | input | 8 | Byte from host |
| rx_valid | input | 1 | Host byte valid |
| rx_ready | output | 1 | Block accepts host byte |
| tx_data | output | 8 | Byte to host |
| tx_valid | output | 1 | Byte to host valid |
| tx_ready | input | 1 | Host accepts byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |
| active | output | 1 | High while bridge mode is active |

## Verification
The assertions check these properties on every cycle:
- the receive and transmit handshakes never overlap;
- the serial clock stays low while chip select is high;
- the shifter runs only under chip select;
- the ready byte is offered when bridge mode starts;
- bridge mode ends with chip select high.

Other behaviour needs the bench's scenarios and its flash model: the ordering and values of bytes on the SPI lines, the zero fill during reads, the exact number of bytes returned, and the single chip-select pulse per frame. The scenarios cover mixed, write-only, read-only, single-byte and maximum-length frames, and the exit frame.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HELLO,
        ST_WCNT,
        ST_RCNT,
        ST_WDATA,
        ST_WSHIFT,
        ST_RSHIFT,
        ST_RPUT,
        ST_CLOSE
    } sfb_state_e;
endpackage

// File: rtl/sfb_shift.sv
module sfb_shift #(
    parameter int DW      = 8,
    parameter int CLK_DIV = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] tx_byte,
    output logic          done,
    output logic          busy,
    output logic [DW-1:0] rx_byte,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(DW);

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] div;
        logic [BIT_W-1:0] bits;
        logic             sclk;
        logic [DW-1:0]    sh;
        logic [DW-1:0]    rx;
        logic             done;
    } shift_t;

    shift_t sh_d, sh_q;
    logic   tick;

    assign tick = (sh_q.div == DIV_W'(CLK_DIV - 1));

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!sh_q.run) begin
            if (start) begin
                sh_d.run  = 1'b1;
                sh_d.sh   = tx_byte;
                sh_d.div  = '0;
                sh_d.bits = '0;
                sh_d.sclk = 1'b0;
            end
        end else if (tick) begin
            sh_d.div  = '0;
            sh_d.sclk = ~sh_q.sclk;
            if (!sh_q.sclk) begin
                sh_d.rx = {sh_q.rx[DW-2:0], miso};
            end else if (sh_q.bits == BIT_W'(DW - 1)) begin
                sh_d.run  = 1'b0;
                sh_d.done = 1'b1;
            end else begin
                sh_d.sh   = sh_q.sh << 1;
                sh_d.bits = sh_q.bits + BIT_W'(1);
            end
        end else begin
            sh_d.div = sh_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign done    = sh_q.done;
    assign busy    = sh_q.run;
    assign rx_byte = sh_q.rx;
    assign sclk    = sh_q.sclk;
    assign mosi    = sh_q.run ? sh_q.sh[DW-1] : 1'b0;

    // R9: clock may only be high while a byte is in flight
    a_r9_sclk_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.sclk |-> sh_q.run);
    // R2: a completed byte always ends with the clock low
    a_r2_done_low: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.done |-> !sh_q.sclk && !sh_q.run);
endmodule

// File: rtl/sfb_ctrl.sv
module sfb_ctrl
    import sfb_pkg::*;
#(
    parameter int          DW         = 8,
    parameter logic [7:0]  READY_CODE = 8'h05
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_valid,
    output logic          rx_ready,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic          sh_start,
    output logic [DW-1:0] sh_byte,
    input  logic          sh_done,
    input  logic [DW-1:0] sh_rx,
    output logic          cs_n,
    output logic          active
);
    typedef struct packed {
        sfb_state_e    st;
        logic [DW-1:0] wcnt;
        logic [DW-1:0] rcnt;
        logic [DW-1:0] resp;
        logic          start;
        logic [DW-1:0] byte_o;
        logic          cs;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        rx_ready = (c_q.st == ST_WCNT) || (c_q.st == ST_RCNT) || (c_q.st == ST_WDATA);
        tx_valid = (c_q.st == ST_HELLO) || (c_q.st == ST_RPUT);
        tx_data  = (c_q.st == ST_HELLO) ? DW'(READY_CODE) : c_q.resp;
    end

    always_comb begin
        c_d       = c_q;
        c_d.start = 1'b0;
        unique case (c_q.st)
            ST_IDLE:  if (enable) c_d.st = ST_HELLO;
            ST_HELLO: if (tx_ready) c_d.st = ST_WCNT;
            ST_WCNT: if (rx_valid) begin
                c_d.wcnt = rx_data;
                c_d.st   = ST_RCNT;
            end
            ST_RCNT: if (rx_valid) begin
                c_d.rcnt = rx_data;
                if (c_q.wcnt == '0 && rx_data == '0) begin
                    c_d.st = ST_IDLE;
                end else begin
                    c_d.cs = 1'b1;
                    if (c_q.wcnt != '0) begin
                        c_d.st = ST_WDATA;
                    end else begin
                        c_d.start  = 1'b1;
                        c_d.byte_o = '0;
                        c_d.st     = ST_RSHIFT;
                    end
                end
            end
            ST_WDATA: if (rx_valid) begin
                c_d.start  = 1'b1;
                c_d.byte_o = rx_data;
                c_d.st     = ST_WSHIFT;
            end
            ST_WSHIFT: if (sh_done) begin
                c_d.wcnt = c_q.wcnt - DW'(1);
                if (c_q.wcnt != DW'(1)) begin
                    c_d.st = ST_WDATA;
                end else if (c_q.rcnt != '0) begin
                    c_d.start  = 1'b1;
                    c_d.byte_o = '0;
                    c_d.st     = ST_RSHIFT;
                end else begin
                    c_d.cs = 1'b0;
                    c_d.st = ST_CLOSE;
                end
            end
            ST_RSHIFT: if (sh_done) begin
                c_d.resp = sh_rx;
                c_d.st   = ST_RPUT;
            end
            ST_RPUT: if (tx_ready) begin
                c_d.rcnt = c_q.rcnt - DW'(1);
                if (c_q.rcnt != DW'(1)) begin
                    c_d.start  = 1'b1;
                    c_d.byte_o = '0;
                    c_d.st     = ST_RSHIFT;
                end else begin
                    c_d.cs = 1'b0;
                    c_d.st = ST_CLOSE;
                end
            end
            ST_CLOSE: c_d.st = ST_WCNT;
            default:  c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign sh_start = c_q.start;
    assign sh_byte  = c_q.byte_o;
    assign cs_n     = ~c_q.cs;
    assign active   = (c_q.st != ST_IDLE);

    // R8: receive and transmit handshakes never offered together
    a_r8_no_rx_while_tx: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);
    // R1: entering bridge mode offers the ready code first
    a_r1_hello: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> tx_valid && tx_data == DW'(READY_CODE));
    // R4: chip select held through data, shift and response states
    a_r4_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_WDATA || c_q.st == ST_WSHIFT || c_q.st == ST_RSHIFT
         || c_q.st == ST_RPUT) |-> !cs_n);
    // R3: a response is only offered while bytes remain owed
    a_r3_resp_owed: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_RPUT) |-> c_q.rcnt != '0);
endmodule

// File: rtl/spi_flash_bridge.sv
module spi_flash_bridge #(
    parameter int         CLK_DIV    = 2,
    parameter logic [7:0] READY_CODE = 8'h05
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    output logic       rx_ready,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       active
);
    localparam int DW = 8;

    logic          sh_start, sh_done, sh_busy;
    logic [DW-1:0] sh_byte, sh_rx;

    sfb_ctrl #(.DW(DW), .READY_CODE(READY_CODE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .sh_start(sh_start), .sh_byte(sh_byte), .sh_done(sh_done),
        .sh_rx(sh_rx), .cs_n(spi_cs_n), .active(active)
    );

    sfb_shift #(.DW(DW), .CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_byte),
        .done(sh_done), .busy(sh_busy), .rx_byte(sh_rx),
        .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
    );

    // R9: serial clock idles low while the flash is deselected
    a_r9_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
    // R4: shifter only runs with chip select asserted
    a_r4_shift_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
        sh_busy |-> !spi_cs_n);
    // R5: leaving bridge mode leaves the flash deselected
    a_r5_exit_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> spi_cs_n);
endmodule

// File: tb/spi_flash_bridge_bench.sv
module spi_flash_bridge_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_valid = 1'b0;
    logic       rx_ready;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic       spi_cs_n, spi_sclk, spi_mosi, spi_miso;
    logic       active;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_flash_bridge u_spi_flash_bridge (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .active(active)
    );

    function automatic logic [7:0] pat(input int b);
        return 8'(8'hA5 + b * 37);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash model: samples MOSI on rising SCLK, advances on falling SCLK
    int         fbyte = 0, fbit = 0, cs_falls = 0;
    logic [7:0] mshift = 8'h00;
    logic [7:0] cur;
    logic [7:0] mosi_log[$];

    always @(negedge spi_cs_n) begin
        fbyte = 0; fbit = 0; cs_falls++;
    end
    always @(posedge spi_sclk) if (!spi_cs_n) mshift = {mshift[6:0], spi_mosi};
    always @(negedge spi_sclk) if (!spi_cs_n) begin
        fbit++;
        if (fbit == 8) begin
            mosi_log.push_back(mshift);
            fbit = 0;
            fbyte++;
        end
    end
    always_comb cur = pat(fbyte);
    assign spi_miso = spi_cs_n ? 1'b0 : cur[3'(7 - fbit)];

    // per-cycle reference checks
    always @(negedge clk) if (rst_n) begin
        check(!(tx_valid && rx_ready), "R8 rx/tx overlap", {tx_valid, rx_ready}, 2);
        check(!(spi_cs_n && spi_sclk), "R9 sclk while deselected", spi_sclk, 0);
    end

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        rx_data  = b;
        rx_valid = 1'b1;
        forever begin
            if (rx_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        #1 rx_valid = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        @(negedge clk);
        tx_ready = 1'b1;
        forever begin
            if (tx_valid) begin
                b = tx_data;
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        #1 tx_ready = 1'b0;
    endtask

    task automatic frame(input int w, input int r, input int seed, input string req);
        int         c0;
        logic [7:0] b;
        mosi_log.delete();
        c0 = cs_falls;
        put(8'(w));
        put(8'(r));
        for (int i = 0; i < w; i++) put(8'(i * 13 + seed));
        for (int i = 0; i < r; i++) begin
            get(b);
            check(b == pat(w + i), {req, " R3 response byte"}, b, pat(w + i));
        end
        @(negedge clk);
        while (!spi_cs_n) @(negedge clk);
        check(cs_falls - c0 == 1, {req, " R4 one chip select"}, cs_falls - c0, 1);
        check(mosi_log.size() == w + r, {req, " R2 byte count on MOSI"}, mosi_log.size(), w + r);
        if (mosi_log.size() == w + r) begin
            for (int i = 0; i < w; i++)
                check(mosi_log[i] == 8'(i * 13 + seed), {req, " R2 MOSI order"},
                      mosi_log[i], 8'(i * 13 + seed));
            for (int i = w; i < w + r; i++)
                check(mosi_log[i] == 8'h00, {req, " R7 zero fill"}, mosi_log[i], 0);
        end
        check(active == 1'b1, {req, " R6 still active"}, active, 1);
    endtask

    task automatic enter();
        logic [7:0] b;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        enable = 1'b0;
        check(active == 1'b1, "R1 active after enable", active, 1);
        check(rx_ready == 1'b0, "R1 no host byte before hello", rx_ready, 0);
        get(b);
        check(b == 8'h05, "R1 ready code", b, 8'h05);
    endtask

    task automatic leave();
        int c0;
        c0 = cs_falls;
        put(8'h00);
        put(8'h00);
        repeat (4) @(negedge clk);
        check(active == 1'b0, "R5 active low after exit", active, 0);
        check(cs_falls == c0, "R5 no chip select on exit", cs_falls - c0, 0);
        check(tx_valid == 1'b0, "R5 nothing offered after exit", tx_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(active == 1'b0, "R11 reset active", active, 0);
        check(spi_cs_n == 1'b1, "R11 reset cs", spi_cs_n, 1);
        check(tx_valid == 1'b0, "R11 reset tx_valid", tx_valid, 0);
        check(rx_ready == 1'b0, "R11 reset rx_ready", rx_ready, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(rx_ready == 1'b0, "R11 idle ignores host", rx_ready, 0);

        enter();
        frame(2, 3, 8'hFE, "mixed");
        frame(1, 1, 8'h3C, "single");
        frame(4, 0, 8'h11, "R6 write-only");
        frame(0, 3, 8'h00, "R6 read-only");
        frame(3, 2, 8'h77, "R6 after one-sided");
        leave();

        enter();
        frame(255, 255, 8'h5A, "R10 max");
        leave();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule